// File: doc/BRIEF.md
# Interrupt-Capable GPIO Port with APB Register Access

This block is a general-purpose I/O controller of up to 32 lines that sits on an APB bus. Software sets each line's drive value and whether it drives at all. It reads back the sampled pad levels through a data word. Every line can raise an interrupt on its own output wire. For each line, software sets whether that interrupt is enabled, whether it reacts to a level or to an edge, and which level or edge direction counts.

Two build-time bitmasks decide which lines exist and which of them can interrupt. Register bits that belong to a missing line, or to a line without interrupt support, ignore writes and read as zero. Software finds the configuration by writing all ones and reading back. A per-line handover bit lets another internal source drive the pad value and enable in place of the register-driven values.

Top module: `apb_gpio_port`

## Requirements
- R1: The APB slave completes every transfer in the access phase without wait states: `pready` is always 1 and `pslverr` is always 0.
- R2: Byte offsets map as follows: 0x00 sampled inputs (read-only, writes ignored), 0x04 drive values, 0x08 drive enables, 0x0C interrupt enables, 0x10 interrupt sense (1 = rising edge or high level, 0 = falling edge or low level), 0x14 trigger kind (1 = edge, 0 = level), 0x18 handover. Reads at offset 0x1C or above return zero.
- R3: After reset, all six writable registers are zero. Every line is therefore an input, `pin_oe` is 0, no interrupt is enabled and no line is handed over.
- R4: A drive-enable bit of 1 sets `pin_oe` for that line, and the drive-value register appears on `pin_out`, one cycle after the write.
- R5: Bits of the drive-value, drive-enable and handover registers for lines outside `IMPL_MASK` ignore writes and read zero. `pin_out` and `pin_oe` stay 0 on those lines.
- R6: Bits of the interrupt-enable, sense and trigger-kind registers are writable only for lines in both `IRQ_MASK` and `IMPL_MASK`. All other bits read zero, and those lines never assert `irq_out`.
- R7: Each input passes through two flops. A change on `pin_in` set up before clock edge k is visible in the input word and to the interrupt logic after edge k+1. Lines outside `IMPL_MASK` read zero.
- R8: A line with trigger kind 0 and interrupt enable 1 holds `irq_out` high for as long as its synchronised input equals its sense bit.
- R9: A line with trigger kind 1 and interrupt enable 1 raises `irq_out` for exactly one cycle per synchronised transition in the sensed direction. A transition in the other direction raises nothing.
- R10: A line whose interrupt-enable bit is 0 keeps `irq_out` low even while its condition holds.
- R11: A line whose handover bit is 1 takes `pin_out` and `pin_oe` from `alt_out` and `alt_oe` instead of the drive registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and block clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always zero |
| pin_in | input | 32 | Pad input levels |
| pin_out | output | 32 | Pad drive values |
| pin_oe | output | 32 | Pad drive enables |
| alt_out | input | 32 | Alternate drive values |
| alt_oe | input | 32 | Alternate drive enables |
| irq_out | output | 32 | Per-line interrupt outputs |

## Verification
The interrupt logic is exercised with a held high level, a rising step and a falling step, each applied to lines set for different trigger kinds and sense bits. This separates level from edge behaviour and rising from falling detection. It also shows that an edge line ignores the opposite transition. The all-ones write-and-read-back pattern, applied to every masked register, tells missing lines and non-interrupt lines apart from the working ones. A mixed value on the handover register, set against distinct register and alternate sources, shows that the source is chosen line by line.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int unsigned LINES = 32;

    typedef enum logic [2:0] {
        W_DIN  = 3'd0,
        W_DOUT = 3'd1,
        W_DIR  = 3'd2,
        W_IEN  = 3'd3,
        W_SNS  = 3'd4,
        W_TRG  = 3'd5,
        W_HND  = 3'd6
    } reg_word_e;

    typedef struct packed {
        logic [LINES-1:0] dout;
        logic [LINES-1:0] dir;
        logic [LINES-1:0] ien;
        logic [LINES-1:0] sense;
        logic [LINES-1:0] trig_edge;
        logic [LINES-1:0] handover;
    } gpio_cfg_t;

    typedef struct packed {
        logic [LINES-1:0] s1;
        logic [LINES-1:0] s2;
        logic [LINES-1:0] prev;
    } gpio_sync_t;

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter logic [31:0] IMPL_MASK = 32'h0000_FFFF,
    parameter logic [31:0] IRQ_MASK  = 32'h0000_00FE,
    parameter int unsigned ADDR_W    = 6
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    input  logic [LINES-1:0]  din,
    output logic [31:0]       prdata,
    output gpio_cfg_t         cfg
);

    localparam int unsigned WORD_W = ADDR_W - 2;
    localparam logic [31:0] IRQ_EFF = IRQ_MASK & IMPL_MASK;

    gpio_cfg_t          cfg_d, cfg_q;
    logic [WORD_W-1:0]  word;
    logic               in_map;
    reg_word_e          sel;
    logic               wr_en;

    assign word   = paddr[ADDR_W-1:2];
    assign in_map = (word < WORD_W'(7));
    assign sel    = reg_word_e'(word[2:0]);
    assign wr_en  = psel && penable && pwrite && in_map;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (sel)
                W_DOUT:  cfg_d.dout      = pwdata & IMPL_MASK;
                W_DIR:   cfg_d.dir       = pwdata & IMPL_MASK;
                W_IEN:   cfg_d.ien       = pwdata & IRQ_EFF;
                W_SNS:   cfg_d.sense     = pwdata & IRQ_EFF;
                W_TRG:   cfg_d.trig_edge = pwdata & IRQ_EFF;
                W_HND:   cfg_d.handover  = pwdata & IMPL_MASK;
                default: cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) cfg_q <= '0;
        else          cfg_q <= cfg_d;
    end

    always_comb begin
        prdata = '0;
        if (in_map) begin
            case (sel)
                W_DIN:   prdata = din & IMPL_MASK;
                W_DOUT:  prdata = cfg_q.dout;
                W_DIR:   prdata = cfg_q.dir;
                W_IEN:   prdata = cfg_q.ien;
                W_SNS:   prdata = cfg_q.sense;
                W_TRG:   prdata = cfg_q.trig_edge;
                W_HND:   prdata = cfg_q.handover;
                default: prdata = '0;
            endcase
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync
    import gpio_port_pkg::*;
#(
    parameter logic [31:0] IMPL_MASK = 32'h0000_FFFF
) (
    input  logic             pclk,
    input  logic             presetn,
    input  logic [LINES-1:0] pin_in,
    output logic [LINES-1:0] sync,
    output logic [LINES-1:0] prev
);

    gpio_sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin_in & IMPL_MASK;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) st_q <= '0;
        else          st_q <= st_d;
    end

    assign sync = st_q.s2;
    assign prev = st_q.prev;

endmodule

// File: rtl/gpio_irq.sv
module gpio_irq
    import gpio_port_pkg::*;
#(
    parameter logic [31:0] IMPL_MASK = 32'h0000_FFFF,
    parameter logic [31:0] IRQ_MASK  = 32'h0000_00FE
) (
    input  gpio_cfg_t        cfg,
    input  logic [LINES-1:0] sync,
    input  logic [LINES-1:0] prev,
    output logic [LINES-1:0] irq
);

    localparam logic [31:0] IRQ_EFF = IRQ_MASK & IMPL_MASK;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        if (IRQ_EFF[i]) begin : g_cap
            logic rise, fall, lvl_hit, edge_hit;
            assign rise     = sync[i] & ~prev[i];
            assign fall     = ~sync[i] & prev[i];
            assign lvl_hit  = cfg.sense[i] ? sync[i] : ~sync[i];
            assign edge_hit = cfg.sense[i] ? rise : fall;
            assign irq[i]   = cfg.ien[i] & (cfg.trig_edge[i] ? edge_hit : lvl_hit);
        end else begin : g_none
            assign irq[i] = 1'b0;
        end
    end

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_port_pkg::*;
#(
    parameter logic [31:0] IMPL_MASK = 32'h0000_FFFF
) (
    input  gpio_cfg_t        cfg,
    input  logic [LINES-1:0] alt_out,
    input  logic [LINES-1:0] alt_oe,
    output logic [LINES-1:0] pin_out,
    output logic [LINES-1:0] pin_oe
);

    for (genvar i = 0; i < LINES; i++) begin : g_pin
        if (IMPL_MASK[i]) begin : g_on
            assign pin_out[i] = cfg.handover[i] ? alt_out[i] : cfg.dout[i];
            assign pin_oe[i]  = cfg.handover[i] ? alt_oe[i]  : cfg.dir[i];
        end else begin : g_off
            assign pin_out[i] = 1'b0;
            assign pin_oe[i]  = 1'b0;
        end
    end

endmodule

// File: rtl/apb_gpio_port.sv
module apb_gpio_port
    import gpio_port_pkg::*;
#(
    parameter logic [31:0] IMPL_MASK = 32'h0000_FFFF,
    parameter logic [31:0] IRQ_MASK  = 32'h0000_00FE,
    parameter int unsigned ADDR_W    = 6
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [31:0]       pin_in,
    output logic [31:0]       pin_out,
    output logic [31:0]       pin_oe,
    input  logic [31:0]       alt_out,
    input  logic [31:0]       alt_oe,
    output logic [31:0]       irq_out
);

    gpio_cfg_t        cfg_q;
    logic [LINES-1:0] sync_v;
    logic [LINES-1:0] prev_v;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    gpio_sync #(.IMPL_MASK(IMPL_MASK)) u_sync (
        .pclk    (pclk),
        .presetn (presetn),
        .pin_in  (pin_in),
        .sync    (sync_v),
        .prev    (prev_v)
    );

    gpio_regs #(.IMPL_MASK(IMPL_MASK), .IRQ_MASK(IRQ_MASK), .ADDR_W(ADDR_W)) u_regs (
        .pclk    (pclk),
        .presetn (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .din     (sync_v),
        .prdata  (prdata),
        .cfg     (cfg_q)
    );

    gpio_irq #(.IMPL_MASK(IMPL_MASK), .IRQ_MASK(IRQ_MASK)) u_irq (
        .cfg  (cfg_q),
        .sync (sync_v),
        .prev (prev_v),
        .irq  (irq_out)
    );

    gpio_pin_mux #(.IMPL_MASK(IMPL_MASK)) u_mux (
        .cfg     (cfg_q),
        .alt_out (alt_out),
        .alt_oe  (alt_oe),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

endmodule

// File: rtl/apb_gpio_port_checker.sv
module apb_gpio_port_checker
    import gpio_port_pkg::*;
#(
    parameter logic [31:0] IMPL_MASK = 32'h0000_FFFF,
    parameter logic [31:0] IRQ_MASK  = 32'h0000_00FE,
    parameter int unsigned ADDR_W    = 6
) (
    input logic              pclk,
    input logic              presetn,
    input logic              psel,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       prdata,
    input logic              pready,
    input logic              pslverr,
    input logic [31:0]       pin_out,
    input logic [31:0]       pin_oe,
    input logic [31:0]       alt_out,
    input logic [31:0]       irq_out,
    input gpio_cfg_t         cfg
);

    p_no_wait_r1: assert property (@(posedge pclk) disable iff (!presetn)
        pready && !pslverr);

    p_oob_zero_r2: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && !pwrite && (paddr[ADDR_W-1:2] > (ADDR_W-2)'(6))) |-> (prdata == 32'h0));

    p_unimpl_quiet_r5: assert property (@(posedge pclk) disable iff (!presetn)
        ((pin_out | pin_oe) & ~IMPL_MASK) == 32'h0);

    p_irq_capable_r6: assert property (@(posedge pclk) disable iff (!presetn)
        (irq_out & ~(IRQ_MASK & IMPL_MASK)) == 32'h0);

    p_edge_single_r9: assert property (@(posedge pclk) disable iff (!presetn)
        $stable(cfg.sense) |->
        ((irq_out & $past(irq_out) & cfg.trig_edge & $past(cfg.trig_edge)) == 32'h0));

    p_mask_gate_r10: assert property (@(posedge pclk) disable iff (!presetn)
        (irq_out & ~cfg.ien) == 32'h0);

    p_handover_r11: assert property (@(posedge pclk) disable iff (!presetn)
        ((pin_out ^ alt_out) & cfg.handover) == 32'h0);

endmodule

bind apb_gpio_port apb_gpio_port_checker #(
    .IMPL_MASK (IMPL_MASK),
    .IRQ_MASK  (IRQ_MASK),
    .ADDR_W    (ADDR_W)
) u_chk (
    .pclk    (pclk),
    .presetn (presetn),
    .psel    (psel),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .prdata  (prdata),
    .pready  (pready),
    .pslverr (pslverr),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .alt_out (alt_out),
    .irq_out (irq_out),
    .cfg     (cfg_q)
);

// File: tb/apb_gpio_port_bench.sv
`timescale 1ns/1ps
module apb_gpio_port_bench;

    localparam int unsigned ADDR_W = 6;

    logic              pclk = 1'b0;
    logic              presetn = 1'b0;
    logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [ADDR_W-1:0] paddr = '0;
    logic [31:0]       pwdata = '0;
    logic [31:0]       prdata;
    logic              pready, pslverr;
    logic [31:0]       pin_in = '0, alt_out = '0, alt_oe = '0;
    logic [31:0]       pin_out, pin_oe, irq_out;

    int checks = 0;
    int errors = 0;

    always #10 pclk = ~pclk;

    apb_gpio_port #(.IMPL_MASK(32'h0000_FFFF), .IRQ_MASK(32'h0000_00FE), .ADDR_W(ADDR_W))
    u_apb_gpio_port (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .alt_out(alt_out),
        .alt_oe(alt_oe), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge pclk); psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge pclk); penable = 1'b1;
        @(negedge pclk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge pclk); psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge pclk); penable = 1'b1; #1 d = prdata;
        @(negedge pclk); psel = 1'b0; penable = 1'b0;
    endtask

    task automatic count_irq(input int line, input int cyc, output int n);
        n = 0;
        for (int c = 0; c < cyc; c++) begin
            @(posedge pclk); #1;
            if (irq_out[line]) n++;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int w = 0; w < 7; w++) begin
            apb_rd(ADDR_W'(w * 4), d);
            chk("R3 reset register", d, 32'h0);
        end
        chk("R3 pin_oe at reset", pin_oe, 32'h0);
        chk("R3 irq at reset", irq_out, 32'h0);
        chk("R1 ready/err", {30'h0, pready, pslverr}, 32'h2);
    endtask

    task automatic t_discover;
        logic [31:0] d;
        apb_wr(6'h04, 32'hFFFF_FFFF); apb_rd(6'h04, d);
        chk("R5 drive value width", d, 32'h0000_FFFF);
        apb_wr(6'h08, 32'hFFFF_FFFF); apb_rd(6'h08, d);
        chk("R5 drive enable width", d, 32'h0000_FFFF);
        chk("R4 pin_oe all", pin_oe, 32'h0000_FFFF);
        chk("R4 pin_out all", pin_out, 32'h0000_FFFF);
        apb_wr(6'h10, 32'hFFFF_FFFF); apb_rd(6'h10, d);
        chk("R6 sense capable lines", d, 32'h0000_00FE);
        apb_wr(6'h0C, 32'hFFFF_FFFF); apb_rd(6'h0C, d);
        chk("R6 enable capable lines", d, 32'h0000_00FE);
        apb_wr(6'h0C, 32'h0); apb_wr(6'h10, 32'h0);
        apb_wr(6'h04, 32'h0000_1234); apb_wr(6'h08, 32'h0000_00F0);
        chk("R4 pin_out mixed", pin_out, 32'h0000_1234);
        chk("R4 pin_oe mixed", pin_oe, 32'h0000_00F0);
        apb_rd(6'h20, d); chk("R2 read 0x20 zero", d, 32'h0);
        apb_rd(6'h3C, d); chk("R2 read 0x3C zero", d, 32'h0);
    endtask

    task automatic t_data;
        logic [31:0] d;
        @(negedge pclk); pin_in = 32'hABCD_5A3C;
        apb_wr(6'h00, 32'hFFFF_FFFF);
        apb_rd(6'h00, d);
        chk("R7 R2 input word", d, 32'h0000_5A3C);
        @(negedge pclk); pin_in = 32'h0;
        repeat (3) @(negedge pclk);
    endtask

    task automatic t_level;
        logic [31:0] d;
        apb_wr(6'h14, 32'h0000_000C);
        apb_wr(6'h10, 32'h0000_0006);
        apb_wr(6'h0C, 32'h0000_000F);
        apb_rd(6'h0C, d);
        chk("R6 enable bit0 ignored", d, 32'h0000_000E);
        chk("R8 idle no irq", irq_out, 32'h0);
        @(negedge pclk); pin_in[1] = 1'b1;
        @(posedge pclk); #1;
        chk("R7 not after one edge", {31'h0, irq_out[1]}, 32'h0);
        @(posedge pclk); #1;
        chk("R8 level high after sync", {31'h0, irq_out[1]}, 32'h1);
        repeat (3) @(posedge pclk); #1;
        chk("R8 level held", {31'h0, irq_out[1]}, 32'h1);
        @(negedge pclk); pin_in[1] = 1'b0;
        repeat (2) @(posedge pclk); #1;
        chk("R8 level released", {31'h0, irq_out[1]}, 32'h0);
    endtask

    task automatic t_edge;
        int n;
        @(negedge pclk); pin_in[2] = 1'b1;
        count_irq(2, 6, n); chk("R9 rising pulse count", n, 1);
        @(negedge pclk); pin_in[3] = 1'b1;
        count_irq(3, 6, n); chk("R9 falling line ignores rise", n, 0);
        @(negedge pclk); pin_in[3] = 1'b0;
        count_irq(3, 6, n); chk("R9 falling pulse count", n, 1);
        @(negedge pclk); pin_in[2] = 1'b0;
        count_irq(2, 6, n); chk("R9 rising line ignores fall", n, 0);
    endtask

    task automatic t_mask;
        repeat (3) @(negedge pclk);
        chk("R10 disabled line quiet", {31'h0, irq_out[4]}, 32'h0);
        apb_wr(6'h0C, 32'h0000_001E);
        chk("R10 enabled low-level fires", {31'h0, irq_out[4]}, 32'h1);
        apb_wr(6'h0C, 32'h0000_000E);
        chk("R10 disabled again", {31'h0, irq_out[4]}, 32'h0);
    endtask

    task automatic t_handover;
        logic [31:0] d;
        @(negedge pclk); alt_out = 32'hFFFF_FFFF; alt_oe = 32'hFFFF_FFFF;
        apb_wr(6'h18, 32'hFFFF_FFFF); apb_rd(6'h18, d);
        chk("R5 handover width", d, 32'h0000_FFFF);
        chk("R5 unimplemented pin_oe zero", pin_oe & 32'hFFFF_0000, 32'h0);
        apb_wr(6'h18, 32'h0000_0101);
        chk("R11 pin_out mixed source", pin_out, 32'h0000_1335);
        chk("R11 pin_oe mixed source", pin_oe, 32'h0000_01F1);
    endtask

    initial begin : watchdog
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge pclk);
        presetn = 1'b1;
        t_reset();
        t_discover();
        t_data();
        t_level();
        t_edge();
        t_mask();
        t_handover();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule